// File: doc/BRIEF.md
# Load Allocation Steering Predictor

This block predicts, for each static load instruction, whether the lines it brings in are read a few times and then abandoned without being written. It keeps a direct-mapped table of small saturating confidence counters indexed by the load's program counter. Every load raises the confidence of its own entry. Every store lowers the confidence of the load that last brought in the stored-to line. When a new line has to be filled, the block answers whether the fill should go to a small read-only side store or to the main direct-mapped L1 data cache.

Stores carry only an address, so the block also keeps an owner table with one slot per L1 line. Each slot records the counter index of the most recent load to that line. A store reads its line's slot to find which counter to weaken. The caches and the L2 path sit outside the block; it only sees load, store and fill events and returns a registered steering answer.

Top module: `load_steer_predictor`

## Requirements
- R1: After reset every confidence counter and every owner slot is zero, so a fill for any PC steers to L1 (steer_side = 0).
- R2: A load increments the counter selected by PC[11:2]. A fill is steered to the side store (steer_side = 1) when that counter is 8 or more (its most significant bit is set). After 7 loads the answer is L1; after 8 loads it is side store.
- R3: Counters saturate at 15: further loads leave the value at 15, so 20 loads followed by 8 stores give 7.
- R4: Counters saturate at 0: a store whose owner counter is 0 leaves it at 0, so one later load gives 1.
- R5: Each load writes its counter index into the owner slot selected by address bits [12:5]. A store reads the slot of its own address bits [12:5] and decrements the counter that slot names.
- R6: The most recent load to a line owns it. After PC D and then PC E load the same line, a store to that line lowers E's counter and leaves D's counter unchanged.
- R7: A load and a store in the same cycle that select the same counter leave it unchanged. The store uses the owner slot as it stood before that cycle's load.
- R8: A fill with fill_in_l1 = 1 (line already resident in L1) is always answered with steer_side = 0, whatever the counter value.
- R9: steer_valid rises exactly one cycle after fill_req. steer_side is judged on the counter value before that edge's load and store updates. steer_side is 0 whenever steer_valid is 0.
- R10: PCs that differ only above bit 11 share one counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load event this cycle |
| ld_pc | input | 32 | Program counter of the load |
| ld_addr | input | 32 | Byte address of the load |
| st_valid | input | 1 | Store event this cycle |
| st_addr | input | 32 | Byte address of the store |
| fill_req | input | 1 | Fill steering request this cycle |
| fill_pc | input | 32 | Program counter of the load causing the fill |
| fill_in_l1 | input | 1 | The referenced line is already resident in L1 |
| steer_valid | output | 1 | Steering answer present (registered) |
| steer_side | output | 1 | 1 = fill into side store, 0 = fill into L1 |

## Verification
Load and store events change a counter at the rising edge on which they are sampled, so a fill issued on the following cycle already sees them. The steering answer for a fill appears one edge after the request. A driver task issues each fill and pushes its expected answer, computed from a count the bench keeps per counter, into a queue. A monitor pops and compares the answer on the falling edge after each cycle that shows steer_valid. A fill issued in the same cycle as a threshold-crossing load is expected to see the old value, which checks R9's ordering.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  // Destination chosen for a newly allocated line.
  typedef enum logic {
    TGT_L1   = 1'b0,
    TGT_SIDE = 1'b1
  } steer_tgt_e;

endpackage

// File: rtl/lsp_conf_table.sv
// Direct-mapped table of saturating confidence counters.
// One increment port (loads) and one decrement port (stores) per cycle.
module lsp_conf_table #(
  parameter int ENTRIES = 1024,
  parameter int CW      = 4,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_en,
  input  logic [IW-1:0] inc_idx,
  input  logic          dec_en,
  input  logic [IW-1:0] dec_idx,
  input  logic [IW-1:0] rd_idx,
  output logic [CW-1:0] rd_val
);

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] CMIN = '0;

  logic [CW-1:0] cnt_q [ENTRIES];

  logic          collide;
  logic          do_inc;
  logic          do_dec;
  logic [CW-1:0] inc_cur;
  logic [CW-1:0] dec_cur;
  logic [CW-1:0] inc_nxt;
  logic [CW-1:0] dec_nxt;

  // Same entry hit by both ports: the two changes cancel.
  assign collide = inc_en && dec_en && (inc_idx == dec_idx);
  assign do_inc  = inc_en && !collide;
  assign do_dec  = dec_en && !collide;

  assign inc_cur = cnt_q[inc_idx];
  assign dec_cur = cnt_q[dec_idx];

  always_comb begin
    inc_nxt = (inc_cur == CMAX) ? CMAX : inc_cur + 1'b1;
    dec_nxt = (dec_cur == CMIN) ? CMIN : dec_cur - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        cnt_q[i] <= '0;
      end
    end else begin
      if (do_inc) cnt_q[inc_idx] <= inc_nxt;
      if (do_dec) cnt_q[dec_idx] <= dec_nxt;
    end
  end

  assign rd_val = cnt_q[rd_idx];

endmodule

// File: rtl/lsp_owner_table.sv
// One slot per L1 line holding the counter index of the last load to it.
module lsp_owner_table #(
  parameter int LINES = 256,
  parameter int OW    = 10,
  localparam int LW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_line,
  input  logic [OW-1:0] wr_owner,
  input  logic [LW-1:0] rd_line,
  output logic [OW-1:0] rd_owner
);

  logic [OW-1:0] slot_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        slot_q[i] <= '0;
      end
    end else if (wr_en) begin
      slot_q[wr_line] <= wr_owner;
    end
  end

  // Read sees the value before this cycle's write.
  assign rd_owner = slot_q[rd_line];

endmodule

// File: rtl/lsp_steer_reg.sv
// Registered steering answer for fill requests.
module lsp_steer_reg #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill_req,
  input  logic          fill_in_l1,
  input  logic [CW-1:0] conf,
  output logic          steer_valid,
  output logic          steer_side
);

  import lsp_pkg::*;

  steer_tgt_e tgt;

  always_comb begin
    tgt = TGT_L1;
    if (fill_req && !fill_in_l1 && conf[CW-1]) tgt = TGT_SIDE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      steer_valid <= 1'b0;
      steer_side  <= 1'b0;
    end else begin
      steer_valid <= fill_req;
      steer_side  <= (tgt == TGT_SIDE);
    end
  end

endmodule

// File: rtl/load_steer_predictor.sv
module load_steer_predictor #(
  parameter int PC_W        = 32,
  parameter int ADDR_W      = 32,
  parameter int CNT_ENTRIES = 1024,
  parameter int CNT_W       = 4,
  parameter int L1_LINES    = 256,
  parameter int LINE_BYTES  = 32,
  parameter int INSN_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              fill_req,
  input  logic [PC_W-1:0]   fill_pc,
  input  logic              fill_in_l1,
  output logic              steer_valid,
  output logic              steer_side
);

  localparam int PIDX_W = $clog2(CNT_ENTRIES);
  localparam int LIDX_W = $clog2(L1_LINES);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int ALN_W  = $clog2(INSN_BYTES);

  logic [PIDX_W-1:0] ld_pidx;
  logic [PIDX_W-1:0] fill_pidx;
  logic [PIDX_W-1:0] st_owner;
  logic [LIDX_W-1:0] ld_line;
  logic [LIDX_W-1:0] st_line;
  logic [CNT_W-1:0]  fill_conf;

  assign ld_pidx   = ld_pc[ALN_W +: PIDX_W];
  assign fill_pidx = fill_pc[ALN_W +: PIDX_W];
  assign ld_line   = ld_addr[OFS_W +: LIDX_W];
  assign st_line   = st_addr[OFS_W +: LIDX_W];

  logic unused_bits;
  assign unused_bits = ^{ld_pc[PC_W-1:ALN_W+PIDX_W], ld_pc[ALN_W-1:0],
                         fill_pc[PC_W-1:ALN_W+PIDX_W], fill_pc[ALN_W-1:0],
                         ld_addr[ADDR_W-1:OFS_W+LIDX_W], ld_addr[OFS_W-1:0],
                         st_addr[ADDR_W-1:OFS_W+LIDX_W], st_addr[OFS_W-1:0]};

  lsp_owner_table #(
    .LINES (L1_LINES),
    .OW    (PIDX_W)
  ) i_owner (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ld_valid),
    .wr_line  (ld_line),
    .wr_owner (ld_pidx),
    .rd_line  (st_line),
    .rd_owner (st_owner)
  );

  lsp_conf_table #(
    .ENTRIES (CNT_ENTRIES),
    .CW      (CNT_W)
  ) i_conf (
    .clk     (clk),
    .rst     (rst),
    .inc_en  (ld_valid),
    .inc_idx (ld_pidx),
    .dec_en  (st_valid),
    .dec_idx (st_owner),
    .rd_idx  (fill_pidx),
    .rd_val  (fill_conf)
  );

  lsp_steer_reg #(
    .CW (CNT_W)
  ) i_steer (
    .clk         (clk),
    .rst         (rst),
    .fill_req    (fill_req),
    .fill_in_l1  (fill_in_l1),
    .conf        (fill_conf),
    .steer_valid (steer_valid),
    .steer_side  (steer_side)
  );

endmodule

// File: rtl/lsp_checker.sv
module lsp_checker (
  input logic clk,
  input logic rst,
  input logic fill_req,
  input logic fill_in_l1,
  input logic steer_valid,
  input logic steer_side
);

  // R9: an answer follows every request one cycle later
  a_r9_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    fill_req |=> steer_valid);

  // R9: no answer without a request
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !fill_req |=> !steer_valid);

  // R9: side steering only accompanies a valid answer
  a_r9_side_needs_valid: assert property (@(posedge clk) disable iff (rst)
    !steer_valid |-> !steer_side);

  // R8: a line already in L1 is never sent to the side store
  a_r8_resident_stays: assert property (@(posedge clk) disable iff (rst)
    (fill_req && fill_in_l1) |=> !steer_side);

endmodule

bind load_steer_predictor lsp_checker i_chk (
  .clk         (clk),
  .rst         (rst),
  .fill_req    (fill_req),
  .fill_in_l1  (fill_in_l1),
  .steer_valid (steer_valid),
  .steer_side  (steer_side)
);

// File: tb/test_load_steer_predictor.sv
module test_load_steer_predictor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_pc = '0;
  logic [31:0] ld_addr = '0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic        fill_req = 1'b0;
  logic [31:0] fill_pc = '0;
  logic        fill_in_l1 = 1'b0;
  logic        steer_valid;
  logic        steer_side;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic  exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;   // 50 MHz

  load_steer_predictor i_load_steer_predictor (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .fill_req(fill_req), .fill_pc(fill_pc), .fill_in_l1(fill_in_l1),
    .steer_valid(steer_valid), .steer_side(steer_side)
  );

  function automatic logic [31:0] line_addr(input int n);
    return 32'h8000_0000 | (32'(n) << 5);
  endfunction

  // Monitor: compares answers on the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (steer_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected answer: actual valid=1 expected valid=0");
        end else begin
          logic  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (steer_side !== e) begin
            fails++;
            $display("FAIL %s steer_side actual=%0b expected=%0b", t, steer_side, e);
          end
        end
      end else if (steer_side !== 1'b0) begin
        checks++;
        fails++;
        $display("FAIL R9 steer_side without valid: actual=%0b expected=0", steer_side);
      end
    end
  end

  task automatic do_load(input logic [31:0] pc, input int line);
    ld_valid = 1'b1; ld_pc = pc; ld_addr = line_addr(line) | 32'h4;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_store(input int line);
    st_valid = 1'b1; st_addr = line_addr(line) | 32'h8;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_load_store(input logic [31:0] pc, input int line);
    ld_valid = 1'b1; ld_pc = pc; ld_addr = line_addr(line);
    st_valid = 1'b1; st_addr = line_addr(line) | 32'h10;
    @(negedge clk);
    ld_valid = 1'b0; st_valid = 1'b0;
  endtask

  task automatic do_fill(input logic [31:0] pc, input logic in_l1,
                         input logic exp_side, input string tag);
    exp_q.push_back(exp_side);
    tag_q.push_back(tag);
    fill_req = 1'b1; fill_pc = pc; fill_in_l1 = in_l1;
    @(negedge clk);
    fill_req = 1'b0; fill_in_l1 = 1'b0;
  endtask

  // Load in the same cycle as a fill for the same PC.
  task automatic do_load_fill(input logic [31:0] pc, input int line,
                              input logic exp_side, input string tag);
    exp_q.push_back(exp_side);
    tag_q.push_back(tag);
    ld_valid = 1'b1; ld_pc = pc; ld_addr = line_addr(line);
    fill_req = 1'b1; fill_pc = pc; fill_in_l1 = 1'b0;
    @(negedge clk);
    ld_valid = 1'b0; fill_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R9: reset state
    checks++;
    if (steer_valid !== 1'b0 || steer_side !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset outputs actual=%0b%0b expected=00", steer_valid, steer_side);
    end
    do_fill(32'h0000_0040, 1'b0, 1'b0, "R1 fresh counter");
    do_fill(32'h0000_0FFC, 1'b0, 1'b0, "R1 fresh counter top entry");

    // R2: threshold at 8
    for (int i = 0; i < 7; i++) do_load(32'h1000_0104, 1);
    do_fill(32'h1000_0104, 1'b0, 1'b0, "R2 seven loads");
    do_load(32'h1000_0104, 1);
    do_fill(32'h1000_0104, 1'b0, 1'b1, "R2 eight loads");

    // R8: resident line stays in L1
    do_fill(32'h1000_0104, 1'b1, 1'b0, "R8 resident line");

    // R3: saturation at 15
    for (int i = 0; i < 20; i++) do_load(32'h0000_0208, 2);
    for (int i = 0; i < 7; i++) do_store(2);
    do_fill(32'h0000_0208, 1'b0, 1'b1, "R3 after seven stores");
    do_store(2);
    do_fill(32'h0000_0208, 1'b0, 1'b0, "R3 after eight stores");

    // R4: saturation at 0
    do_load(32'h0000_030C, 3);
    for (int i = 0; i < 3; i++) do_store(3);
    do_load(32'h0000_030C, 3);
    do_fill(32'h0000_030C, 1'b0, 1'b0, "R4 floor then one load");

    // R5 / R6: owner tracking
    for (int i = 0; i < 8; i++) do_load(32'h0000_0040, 5);
    for (int i = 0; i < 8; i++) do_load(32'h0000_0044, 5);
    do_store(5);
    do_fill(32'h0000_0040, 1'b0, 1'b1, "R6 earlier owner untouched");
    do_fill(32'h0000_0044, 1'b0, 1'b0, "R5 store lowers owner");

    // R7: same-cycle load and store on one counter
    for (int i = 0; i < 8; i++) do_load(32'h0000_0050, 6);
    for (int i = 0; i < 4; i++) do_load_store(32'h0000_0050, 6);
    do_fill(32'h0000_0050, 1'b0, 1'b1, "R7 net zero");
    do_store(6);
    do_fill(32'h0000_0050, 1'b0, 1'b0, "R7 then one store");

    // R10: aliasing above bit 11
    for (int i = 0; i < 8; i++) do_load(32'hABC0_0060, 7);
    do_fill(32'h0000_0060, 1'b0, 1'b1, "R10 alias shares counter");

    // R9: fill sees state before the same-cycle load
    for (int i = 0; i < 7; i++) do_load(32'h0000_0070, 8);
    do_load_fill(32'h0000_0070, 8, 1'b0, "R9 same-cycle load not seen");
    do_fill(32'h0000_0070, 1'b0, 1'b1, "R9 load seen next cycle");

    // R9: back-to-back fills
    do_fill(32'h0000_0060, 1'b0, 1'b1, "R9 back-to-back first");
    do_fill(32'h0000_030C, 1'b0, 1'b0, "R9 back-to-back second");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9 missing answers: actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule